// File: doc/BRIEF.md
# Multi-Mode Reloading Down Counter

This block is a programmable down-counter with a reload latch. Each time the counter passes zero it reloads from the latch, raises a sticky interrupt request and, in one mode, flips a toggle output. A prescaler produces the count ticks. It divides an incoming source-enable pulse by 1, 2, 16 or 256. An external pin passes through a synchronizer, and the counter can use that pin either as an event source or as a level gate.

Four modes are available. The first is a plain periodic timer. The second is the same timer with a square-wave toggle output. The third counts events on the pin, and its counting window opens and closes on underflow strobes from a companion timer. The fourth measures pulse width by counting prescaler ticks while the pin is at a chosen level. In the timer, event and width modes, a two-bit extension latch widens the reload value from 16 to 18 bits.

Software loads a reload value while the counter is stopped, which also presets the counter. It then selects a mode, clears the stop bit, and services the interrupt request by clearing it.

Top module: `mm_down_timer`

## Requirements
- R1: The prescaler turns `src_tick` pulses into count ticks. The ratio is set by `cfg_div`: 0 gives 1/1, 1 gives 1/2, 2 gives 1/16 and 3 gives 1/256. A configuration write restarts the prescaler, so the first tick after the write comes on the Nth source pulse.
- R2: The counter decrements by one on each count pulse. A count pulse that arrives while the counter is zero causes an underflow, which loads the reload value instead.
- R3: Every underflow sets `irq_req`. It stays set until `irq_clr` is pulsed. If an underflow and a clear happen in the same cycle, the request stays set.
- R4: In modes 0 (timer), 2 (event) and 3 (width), the reload value is {extension, reload latch} and is 18 bits wide. In mode 1 (pulse), the extension bits are read as zero.
- R5: In mode 1, `tog_out` inverts on every underflow. Otherwise mode 1 counts exactly like mode 0. In every other mode `tog_out` holds its level.
- R6: In mode 2, the counter decrements once per rising edge of the synchronized `evt_pin`. A long high level counts only once.
- R7: In mode 2, a `win_strobe` pulse while `cfg_win` is 1 closes the event window, and edges no longer count. A `win_strobe` pulse while `cfg_win` is 0 opens it again. Changing `cfg_win` has no effect until the next strobe. The window is open after reset.
- R8: In mode 3, the counter decrements on prescaler ticks. With `cfg_pol` = 0 it counts only while the synchronized pin is high, and with `cfg_pol` = 1 only while the pin is low.
- R9: While the stop bit is set, the counter holds its value. A reload write while stopped also loads the counter with the new reload value. A reload write while running changes only the latch.
- R10: Reset clears the counter, `tog_out`, `irq_req`, the latches and the configuration, and sets the stop bit.
- R11: `evt_pin` passes through two flops before edge or level detection. A rising edge of the pin before clock edge k changes the counter at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 1 | Source enable pulse fed to the prescaler |
| evt_pin | input | 1 | External event / level input (asynchronous) |
| win_strobe | input | 1 | Underflow strobe from the companion timer |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_mode | input | 2 | Mode: 0 timer, 1 pulse, 2 event, 3 width |
| cfg_div | input | 2 | Prescaler ratio code |
| cfg_win | input | 1 | Window control applied at the next strobe |
| cfg_pol | input | 1 | Width-mode level polarity |
| cfg_stop | input | 1 | Stop bit (1 = counter held) |
| reload_we | input | 1 | Write strobe for the reload latch |
| reload_data | input | 16 | Reload latch value |
| ext_we | input | 1 | Write strobe for the extension latch |
| ext_data | input | 2 | Extension latch value (reload bits 17:16) |
| irq_clr | input | 1 | Clears the interrupt request |
| cnt_val | output | 18 | Current counter value |
| tog_out | output | 1 | Toggle output |
| irq_req | output | 1 | Sticky underflow interrupt request |

## Verification
The bench sets the counter to zero and lands an interrupt clear on the same cycle as the underflow. A design that let the clear win would lose a request. It times the first event edge to the exact cycle, which catches a synchronizer with one flop too many or too few. It also holds the pin high for several cycles, so an edge detector that counts levels would over-count. Window tests change `cfg_win` without a strobe and check that counting continues until the strobe arrives. Other tests load a reload value while running, and load the extension in pulse mode. A design that presets the counter during a running write, or that does not mask the extension in pulse mode, shows the wrong count at once.

// File: rtl/tmr_pkg.sv
// Shared types for the multi-mode down-counter.
// Assumes: prescaler counter at least 8 bits wide so the largest ratio fits.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'd0,
        MODE_PULSE = 2'd1,
        MODE_EVENT = 2'd2,
        MODE_WIDTH = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e  mode;
        logic [1:0] div;
        logic       win;
        logic       pol;
        logic       stop;
    } tmr_cfg_t;

    // Number of low prescaler bits that must be all ones for a tick.
    function automatic int unsigned div_shift(input logic [1:0] code);
        case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: counts source pulses and emits a tick every 1, 2, 16 or 256
// source pulses. A restart puts the phase back to zero.
// Assumes: PRE_W >= 8; src_tick is a single-cycle enable.
module tmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_tick,
    input  logic       restart,
    input  logic [1:0] div_sel,
    output logic       tick_o
);
    import tmr_pkg::*;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Select which low bits of the phase counter must be all ones.
    always_comb begin
        mask   = (PRE_W'(1) << div_shift(div_sel)) - PRE_W'(1);
        tick_o = src_tick && ((pre_q & mask) == mask);
    end

    // Phase counter: cleared by restart, advanced by each source pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (restart)  pre_q <= '0;
        else if (src_tick) pre_q <= pre_q + PRE_W'(1);
    end

    p_tick_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> src_tick);

    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));

endmodule

// File: rtl/tmr_sync.sv
// Input synchronizer with edge detection: STAGES flops bring the pin into
// the clock domain, and one more flop gives the rising-edge pulse.
// Assumes: pin_i is asynchronous; rise_o is one cycle wide.
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o
);
    logic [STAGES:0] sr_q;

    // Shift chain: sync stages followed by the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-1:0], pin_i};
    end

    // Level and edge taken from the end of the chain.
    always_comb begin
        lvl_o  = sr_q[STAGES-1];
        rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
    end

    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tmr_core.sv
// Counter core: reload and extension latches, the down-counter, window
// state, toggle output and sticky interrupt request.
// Assumes: cfg is registered; pre_tick/evt_rise are single-cycle pulses.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int LAT_W = 16,
    parameter int EXT_W = 2,
    localparam int CNT_W = LAT_W + EXT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_cfg_t         cfg,
    input  logic             pre_tick,
    input  logic             evt_lvl,
    input  logic             evt_rise,
    input  logic             win_strobe,
    input  logic             reload_we,
    input  logic [LAT_W-1:0] reload_data,
    input  logic             ext_we,
    input  logic [EXT_W-1:0] ext_data,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tog_o,
    output logic             irq_o
);
    logic [LAT_W-1:0] lat_q, lat_nxt;
    logic [EXT_W-1:0] ext_q, ext_nxt;
    logic [CNT_W-1:0] cnt_q, reload_full, load_full;
    logic             win_open_q;
    logic             tog_q, irq_q;
    logic             src_en, cnt_en, uf;

    // Width of the reload value depends on the mode.
    function automatic logic [CNT_W-1:0] widen(input tmr_mode_e m,
                                               input logic [EXT_W-1:0] e,
                                               input logic [LAT_W-1:0] l);
        if (m == MODE_PULSE) return {{EXT_W{1'b0}}, l};
        return {e, l};
    endfunction

    // Next latch contents and the two reload forms.
    always_comb begin
        lat_nxt     = reload_we ? reload_data : lat_q;
        ext_nxt     = ext_we ? ext_data : ext_q;
        reload_full = widen(cfg.mode, ext_q, lat_q);
        load_full   = widen(cfg.mode, ext_nxt, lat_nxt);
    end

    // Count-pulse selection per mode, gated by the stop bit.
    always_comb begin
        case (cfg.mode)
            MODE_EVENT: src_en = evt_rise && win_open_q;
            MODE_WIDTH: src_en = pre_tick && (evt_lvl != cfg.pol);
            default:    src_en = pre_tick;
        endcase
        cnt_en = !cfg.stop && src_en;
        uf     = cnt_en && (cnt_q == '0);
    end

    // Reload and extension latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            ext_q <= '0;
        end else begin
            lat_q <= lat_nxt;
            ext_q <= ext_nxt;
        end
    end

    // Down-counter: reload on underflow, preset on a stopped reload write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (uf)                    cnt_q <= reload_full;
        else if (cnt_en)                cnt_q <= cnt_q - CNT_W'(1);
        else if (reload_we && cfg.stop) cnt_q <= load_full;
    end

    // Event window: each companion strobe applies the window-control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          win_open_q <= 1'b1;
        else if (win_strobe) win_open_q <= !cfg.win;
    end

    // Toggle output flips on underflow in pulse mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          tog_q <= 1'b0;
        else if (uf && cfg.mode == MODE_PULSE) tog_q <= !tog_q;
    end

    // Sticky interrupt request; a new underflow beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (uf)      irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign cnt_o = cnt_q;
    assign tog_o = tog_q;
    assign irq_o = irq_q;

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (cnt_q == $past(reload_full)));

    p_irq_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> irq_q);

    p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr) |=> irq_q);

    p_ext_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && cfg.mode == MODE_PULSE) |=> (cnt_q[CNT_W-1:LAT_W] == '0));

    p_tog_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(uf && cfg.mode == MODE_PULSE) |=> $stable(tog_q));

    p_win_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_EVENT && !win_open_q && !reload_we) |=> $stable(cnt_q));

    p_width_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_WIDTH && evt_lvl == cfg.pol && !reload_we) |=> $stable(cnt_q));

    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.stop && !reload_we) |=> $stable(cnt_q));

endmodule

// File: rtl/mm_down_timer.sv
// Top of the multi-mode reloading down-counter: holds the configuration
// register and ties the prescaler, pin synchronizer and counter core.
// Assumes: all write strobes are single-cycle and synchronous to clk.
module mm_down_timer
    import tmr_pkg::*;
#(
    parameter int LAT_W    = 16,
    parameter int EXT_W    = 2,
    parameter int PRE_W    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_tick,
    input  logic                   evt_pin,
    input  logic                   win_strobe,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_mode,
    input  logic [1:0]             cfg_div,
    input  logic                   cfg_win,
    input  logic                   cfg_pol,
    input  logic                   cfg_stop,
    input  logic                   reload_we,
    input  logic [LAT_W-1:0]       reload_data,
    input  logic                   ext_we,
    input  logic [EXT_W-1:0]       ext_data,
    input  logic                   irq_clr,
    output logic [LAT_W+EXT_W-1:0] cnt_val,
    output logic                   tog_out,
    output logic                   irq_req
);
    tmr_cfg_t cfg_q;
    logic     pre_tick, evt_lvl, evt_rise;

    // Configuration register; reset leaves the counter stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_TIMER, div: 2'd0, win: 1'b0, pol: 1'b0, stop: 1'b1};
        end else if (cfg_we) begin
            cfg_q <= '{mode: tmr_mode_e'(cfg_mode), div: cfg_div, win: cfg_win,
                       pol: cfg_pol, stop: cfg_stop};
        end
    end

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .restart  (cfg_we),
        .div_sel  (cfg_q.div),
        .tick_o   (pre_tick)
    );

    tmr_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (evt_pin),
        .lvl_o  (evt_lvl),
        .rise_o (evt_rise)
    );

    tmr_core #(.LAT_W(LAT_W), .EXT_W(EXT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg_q),
        .pre_tick    (pre_tick),
        .evt_lvl     (evt_lvl),
        .evt_rise    (evt_rise),
        .win_strobe  (win_strobe),
        .reload_we   (reload_we),
        .reload_data (reload_data),
        .ext_we      (ext_we),
        .ext_data    (ext_data),
        .irq_clr     (irq_clr),
        .cnt_o       (cnt_val),
        .tog_o       (tog_out),
        .irq_o       (irq_req)
    );

endmodule

// File: tb/test_mm_down_timer.sv
`timescale 1ns/1ps
module test_mm_down_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        src_tick, evt_pin, win_strobe;
    logic        cfg_we, cfg_win, cfg_pol, cfg_stop;
    logic [1:0]  cfg_mode, cfg_div;
    logic        reload_we, ext_we, irq_clr;
    logic [15:0] reload_data;
    logic [1:0]  ext_data;
    logic [17:0] cnt_val;
    logic        tog_out, irq_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mm_down_timer i_mm_down_timer (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .evt_pin(evt_pin),
        .win_strobe(win_strobe), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_div(cfg_div), .cfg_win(cfg_win), .cfg_pol(cfg_pol),
        .cfg_stop(cfg_stop), .reload_we(reload_we), .reload_data(reload_data),
        .ext_we(ext_we), .ext_data(ext_data), .irq_clr(irq_clr),
        .cnt_val(cnt_val), .tog_out(tog_out), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] d,
                           input logic w, input logic p, input logic s);
        cfg_mode = m; cfg_div = d; cfg_win = w; cfg_pol = p; cfg_stop = s;
        cfg_we = 1'b1; step(1); cfg_we = 1'b0;
    endtask

    task automatic wr_reload(input logic [15:0] v);
        reload_data = v; reload_we = 1'b1; step(1); reload_we = 1'b0;
    endtask

    task automatic wr_ext(input logic [1:0] v);
        ext_data = v; ext_we = 1'b1; step(1); ext_we = 1'b0;
    endtask

    task automatic pin_pulse();
        evt_pin = 1'b1; step(3); evt_pin = 1'b0; step(3);
    endtask

    task automatic strobe();
        win_strobe = 1'b1; step(1); win_strobe = 1'b0;
    endtask

    // R10 and R9: reset state, stopped counter holds.
    task automatic t_reset();
        chk("R10 cnt after reset", cnt_val, 0);
        chk("R10 tog after reset", tog_out, 0);
        chk("R10 irq after reset", irq_req, 0);
        step(5);
        chk("R9 stopped after reset", cnt_val, 0);
    endtask

    // R2, R3, R9: timer mode underflow, irq and set-wins.
    task automatic t_timer();
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_reload(16'd3);
        chk("R9 stopped load", cnt_val, 3);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        chk("R2 first cycle", cnt_val, 3);
        step(3);
        chk("R2 reach zero", cnt_val, 0);
        chk("R3 no irq before uf", irq_req, 0);
        step(1);
        chk("R2 reload on uf", cnt_val, 3);
        chk("R3 irq set", irq_req, 1);
        step(3);
        chk("R2 zero again", cnt_val, 0);
        irq_clr = 1'b1; step(1);
        chk("R3 set wins over clear", irq_req, 1);
        step(1); irq_clr = 1'b0;
        chk("R3 clear", irq_req, 0);
        chk("R5 tog held in timer", tog_out, 0);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    endtask

    // R1: prescaler ratios, R9: running write does not preset.
    task automatic t_prescale();
        int gap[3] = '{2, 16, 256};
        for (int i = 0; i < 3; i++) begin
            set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
            wr_reload(16'd50);
            set_cfg(2'd0, 2'(i + 1), 1'b0, 1'b0, 1'b0);
            step(gap[i] - 1);
            chk("R1 before tick", cnt_val, 50);
            step(1);
            chk("R1 on tick", cnt_val, 49);
        end
        wr_reload(16'd7);
        step(2);
        chk("R9 running write no preset", cnt_val, 49);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    endtask

    // R5 and R4: toggle output, extension masked in pulse mode.
    task automatic t_pulse();
        set_cfg(2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_ext(2'd3);
        wr_reload(16'd2);
        chk("R4 ext masked in pulse", cnt_val, 2);
        set_cfg(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
        step(3);
        chk("R5 toggle first uf", tog_out, 1);
        chk("R4 pulse reload masked", cnt_val, 2);
        step(3);
        chk("R5 toggle second uf", tog_out, 0);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_ext(2'd0);
    endtask

    // R4: 18-bit counting in timer mode.
    task automatic t_ext();
        wr_ext(2'd1);
        wr_reload(16'd0);
        chk("R4 ext preset", cnt_val, 32'h10000);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        step(1);
        chk("R4 ext decrement", cnt_val, 32'h0FFFF);
        set_cfg(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_ext(2'd0);
    endtask

    // R6, R7, R11: event counting, window, sync latency.
    task automatic t_event();
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_reload(16'd100);
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
        evt_pin = 1'b1;
        step(2);
        chk("R11 no count at k+1", cnt_val, 100);
        step(1);
        chk("R11 count at k+2", cnt_val, 99);
        step(1); evt_pin = 1'b0; step(3);
        chk("R6 long high counts once", cnt_val, 99);
        for (int i = 0; i < 4; i++) pin_pulse();
        chk("R6 edges counted", cnt_val, 95);
        set_cfg(2'd2, 2'd0, 1'b1, 1'b0, 1'b0);
        pin_pulse();
        chk("R7 open until strobe", cnt_val, 94);
        strobe();
        for (int i = 0; i < 3; i++) pin_pulse();
        chk("R7 closed window", cnt_val, 94);
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
        pin_pulse();
        chk("R7 closed until strobe", cnt_val, 94);
        strobe();
        for (int i = 0; i < 2; i++) pin_pulse();
        chk("R7 reopened", cnt_val, 92);
        set_cfg(2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
    endtask

    // R8: pulse-width measurement, both polarities.
    task automatic t_width();
        evt_pin = 1'b0;
        set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
        wr_reload(16'd200);
        set_cfg(2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
        step(4);
        chk("R8 low not counted pol0", cnt_val, 200);
        evt_pin = 1'b1; step(10); evt_pin = 1'b0; step(5);
        chk("R8 high width pol0", cnt_val, 190);
        evt_pin = 1'b1;
        set_cfg(2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
        wr_reload(16'd200);
        step(3);
        set_cfg(2'd3, 2'd0, 1'b0, 1'b1, 1'b0);
        step(20);
        chk("R8 high not counted pol1", cnt_val, 200);
        evt_pin = 1'b0; step(7); evt_pin = 1'b1; step(5);
        chk("R8 low width pol1", cnt_val, 193);
        set_cfg(2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_tick = 1'b1; evt_pin = 1'b0; win_strobe = 1'b0;
        cfg_we = 1'b0; cfg_mode = 2'd0; cfg_div = 2'd0; cfg_win = 1'b0;
        cfg_pol = 1'b0; cfg_stop = 1'b1; reload_we = 1'b0; reload_data = '0;
        ext_we = 1'b0; ext_data = '0; irq_clr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_timer();
        t_prescale();
        t_pulse();
        t_ext();
        t_event();
        t_width();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule